// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the serial test port of a memory device. A four-wire serial interface carries the signals: test clock, mode select, serial data in and serial data out. It also has an active-low asynchronous reset for the test logic. A sixteen-state controller walks the standard scan graph on the mode-select value sampled at each rising test clock. A three-bit instruction chooses which data register sits between serial-in and serial-out. The choices are a one-bit bypass stage, a 32-bit identification word, and a boundary register of parameterised length that snapshots a parallel I/O ring.

The instruction also sets a single output-disable line. This line forces the device's data drivers to high impedance for the two instructions that isolate the pins. The boundary register only captures and shifts. It never drives the ring, so both the external-test instruction and the sample instruction are capture-only.

Serial-out changes on the falling test clock. Its enable is high only while a register is shifting.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state scan graph on mode-select at each rising clock. In particular: the reset state holds on mode-select 1; Select-IR with mode-select 1 returns to reset; Pause with 1 goes to Exit2; Exit2 with 0 returns to Shift.
- R2: Asynchronous reset, or five consecutive rising clocks with mode-select 1 from any state, puts the controller in the reset state. It also loads opcode 001 (identification) into the active instruction and drops output-disable to 0.
- R3: Capture-IR loads the pattern 001 into the instruction shift stage, which shifts out LSB first. A newly shifted opcode only takes effect at Update-IR, so output-disable does not change while the instruction is being shifted.
- R4: Opcode 000 (external test) selects the boundary register, captures the ring into it at Capture-DR, and drives output-disable to 1.
- R5: Opcode 010 (isolated sample) selects and captures the boundary register and drives output-disable to 1.
- R6: Opcode 100 (sample) selects and captures the boundary register with output-disable at 0.
- R7: Opcode 001 selects the 32-bit identification register, which loads the ID_CODE parameter at Capture-DR. Output-disable is 0.
- R8: Opcode 111 selects the one-bit bypass register, which captures 0. Serial data then reappears on serial-out one clock later. Output-disable is 0.
- R9: Reserved opcodes 011, 101 and 110 behave as bypass for the data path and keep output-disable at 0.
- R10: Serial-out and its enable change on the falling clock. The enable is 1 only in Shift-DR and Shift-IR. Every register shifts LSB first, with serial-in entering at the MSB.
- R11: Passing through Exit1, Pause and Exit2 and back into Shift-DR keeps the partly shifted register contents. Shifting resumes where it stopped.
- R12: The ring input is sampled only at Capture-DR. Ring changes during shifting do not alter the data scanned out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test-logic reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| ioRing | input | BSR_LEN | Parallel I/O ring snapshot for the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdoEn | output | 1 | Drive enable for tdo; low means high impedance |
| outDisable | output | 1 | Forces the device's data drivers to high impedance |

## Verification
The assertions assume that mode-select and serial-in settle well away from the rising clock edge. They also assume that asynchronous reset is released while the clock is low, so the controller state is never metastable. The bench changes inputs a short time after each falling edge and releases reset between edges. It sweeps all eight opcodes, with a distinct ring value for each and a pause detour on two of them. Because the reset state is reachable only through Select-IR, the stability checks on output-disable depend on the controller never skipping states.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    DR_SELECT, DR_CAPTURE, DR_SHIFT, DR_EXIT1, DR_PAUSE, DR_EXIT2, DR_UPDATE,
    IR_SELECT, IR_CAPTURE, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPDATE
  } tapState_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] { SEL_BYPASS, SEL_ID, SEL_BSR } drSel_e;

  typedef struct packed {
    logic   capDr;
    logic   shDr;
    logic   shIr;
    drSel_e sel;
  } tapStrobe_t;
endpackage

// File: rtl/scan_tap_shreg.sv
module scan_tap_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         capEn,
  input  logic         shEn,
  input  logic [W-1:0] capVal,
  input  logic         tdi,
  output logic         lsb
);
  logic [W-1:0] stage;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck) begin
        if (capEn)      stage <= capVal;
        else if (shEn)  stage <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck) begin
        if (capEn)      stage <= capVal;
        else if (shEn)  stage <= {tdi, stage[W-1:1]};
      end
    end
  endgenerate

  assign lsb = stage[0];
endmodule

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapState_e  state,
  output tapStrobe_t strobe,
  output logic       irLsb,
  output logic       outDisable
);
  tapState_e nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irCur;

  always_comb begin
    nextState = state;
    case (state)
      TAP_RESET:  nextState = tms ? TAP_RESET : TAP_IDLE;
      TAP_IDLE:   nextState = tms ? DR_SELECT : TAP_IDLE;
      DR_SELECT:  nextState = tms ? IR_SELECT : DR_CAPTURE;
      DR_CAPTURE: nextState = tms ? DR_EXIT1  : DR_SHIFT;
      DR_SHIFT:   nextState = tms ? DR_EXIT1  : DR_SHIFT;
      DR_EXIT1:   nextState = tms ? DR_UPDATE : DR_PAUSE;
      DR_PAUSE:   nextState = tms ? DR_EXIT2  : DR_PAUSE;
      DR_EXIT2:   nextState = tms ? DR_UPDATE : DR_SHIFT;
      DR_UPDATE:  nextState = tms ? DR_SELECT : TAP_IDLE;
      IR_SELECT:  nextState = tms ? TAP_RESET : IR_CAPTURE;
      IR_CAPTURE: nextState = tms ? IR_EXIT1  : IR_SHIFT;
      IR_SHIFT:   nextState = tms ? IR_EXIT1  : IR_SHIFT;
      IR_EXIT1:   nextState = tms ? IR_UPDATE : IR_PAUSE;
      IR_PAUSE:   nextState = tms ? IR_EXIT2  : IR_PAUSE;
      IR_EXIT2:   nextState = tms ? IR_UPDATE : IR_SHIFT;
      IR_UPDATE:  nextState = tms ? DR_SELECT : TAP_IDLE;
      default:    nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= TAP_RESET;
    else        state <= nextState;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE_PAT;
      irCur   <= OP_IDCODE;
    end else begin
      if (state == IR_CAPTURE)    irShift <= IR_CAPTURE_PAT;
      else if (state == IR_SHIFT) irShift <= {tdi, irShift[IR_W-1:1]};
      if (nextState == TAP_RESET)    irCur <= OP_IDCODE;
      else if (state == IR_UPDATE)   irCur <= irShift;
    end
  end

  always_comb begin
    strobe.capDr = (state == DR_CAPTURE);
    strobe.shDr  = (state == DR_SHIFT);
    strobe.shIr  = (state == IR_SHIFT);
    case (irCur)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: strobe.sel = SEL_BSR;
      OP_IDCODE:                        strobe.sel = SEL_ID;
      default:                          strobe.sel = SEL_BYPASS;
    endcase
  end

  assign outDisable = (irCur == OP_EXTEST) || (irCur == OP_SAMPLEZ);
  assign irLsb      = irShift[0];
endmodule

// File: rtl/scan_tap_dp.sv
module scan_tap_dp
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 12,
  parameter logic [31:0] ID_CODE = 32'h1A5B_3C4D
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ioRing,
  input  tapStrobe_t         strobe,
  input  logic               irLsb,
  output logic               tdo,
  output logic               tdoEn
);
  localparam int ID_W = 32;

  logic bypLsb, idLsb, bsrLsb;
  logic drLsb;

  scan_tap_shreg #(.W(1)) u_bypass (
    .tck(tck), .capEn(strobe.capDr && strobe.sel == SEL_BYPASS),
    .shEn(strobe.shDr && strobe.sel == SEL_BYPASS),
    .capVal(1'b0), .tdi(tdi), .lsb(bypLsb));

  scan_tap_shreg #(.W(ID_W)) u_ident (
    .tck(tck), .capEn(strobe.capDr && strobe.sel == SEL_ID),
    .shEn(strobe.shDr && strobe.sel == SEL_ID),
    .capVal(ID_CODE), .tdi(tdi), .lsb(idLsb));

  scan_tap_shreg #(.W(BSR_LEN)) u_bsr (
    .tck(tck), .capEn(strobe.capDr && strobe.sel == SEL_BSR),
    .shEn(strobe.shDr && strobe.sel == SEL_BSR),
    .capVal(ioRing), .tdi(tdi), .lsb(bsrLsb));

  always_comb begin
    case (strobe.sel)
      SEL_ID:  drLsb = idLsb;
      SEL_BSR: drLsb = bsrLsb;
      default: drLsb = bypLsb;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shDr || strobe.shIr;
      tdo   <= strobe.shIr ? irLsb : drLsb;
    end
  end
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 12,
  parameter logic [31:0] ID_CODE = 32'h1A5B_3C4D
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ioRing,
  output logic               tdo,
  output logic               tdoEn,
  output logic               outDisable
);
  tapState_e  state;
  tapStrobe_t strobe;
  logic       irLsb;

  scan_tap_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .state(state), .strobe(strobe), .irLsb(irLsb), .outDisable(outDisable));

  scan_tap_dp #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .ioRing(ioRing),
    .strobe(strobe), .irLsb(irLsb), .tdo(tdo), .tdoEn(tdoEn));
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic      tck,
  input logic      trstN,
  input logic      tms,
  input tapState_e state,
  input logic      tdoEn,
  input logic      outDisable
);
  a_r1_reset_hold: assert property (@(posedge tck) disable iff (!trstN)
    (state == TAP_RESET && tms) |=> state == TAP_RESET);

  a_r1_irsel_escape: assert property (@(posedge tck) disable iff (!trstN)
    (state == IR_SELECT && tms) |=> state == TAP_RESET);

  a_r1_pause_to_exit2: assert property (@(posedge tck) disable iff (!trstN)
    (state == DR_PAUSE && tms) |=> state == DR_EXIT2);

  a_r11_exit2_resume: assert property (@(posedge tck) disable iff (!trstN)
    (state == DR_EXIT2 && !tms) |=> state == DR_SHIFT);

  a_r2_reset_enables_drivers: assert property (@(posedge tck) disable iff (!trstN)
    state == TAP_RESET |-> !outDisable);

  a_r3_disable_waits_update: assert property (@(posedge tck) disable iff (!trstN)
    (state != IR_UPDATE && state != IR_SELECT) |=> $stable(outDisable));

  a_r10_tdo_only_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (state == DR_SHIFT || state == IR_SHIFT));
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .trstN(trstN), .tms(tms), .state(u_ctrl.state),
  .tdoEn(tdoEn), .outDisable(outDisable));

// File: tb/scan_tap_tb.sv
module scan_tap_tb;
  localparam int          BSR_LEN = 12;
  localparam logic [31:0] ID_CODE = 32'h1A5B_3C4D;
  localparam int          SCAN_N  = 48;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BSR_LEN-1:0] ioRing = '0;
  logic tdo, tdoEn, outDisable;
  logic lastTdo, lastEn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .ioRing(ioRing),
    .tdo(tdo), .tdoEn(tdoEn), .outDisable(outDisable));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample outputs set at the falling edge, then present new inputs
  task automatic step(input logic m, input logic d);
    @(negedge tck); #2;
    lastTdo = tdo; lastEn = tdoEn;
    tms = m; tdi = d;
    @(posedge tck); #2;
  endtask

  task automatic loadIr(input logic [2:0] code);
    logic [2:0] irOut;
    logic prevDis;
    prevDis = outDisable;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      irOut[i] = lastTdo;
      check(lastEn === 1'b1, "R10 tdoEn in Shift-IR", {63'd0, lastEn}, 64'd1);
    end
    check(irOut === 3'b001, "R3 capture pattern", {61'd0, irOut}, 64'd1);
    check(outDisable === prevDis, "R3 no effect before update",
          {63'd0, outDisable}, {63'd0, prevDis});
    step(1, 0); step(0, 0);
  endtask

  // from Idle: capture, shift SCAN_N bits, optional pause detour, back to Idle
  task automatic scanDr(input logic [63:0] pattern, input int pauseAt,
                        input bit flipRing, output logic [63:0] outBits);
    outBits = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < SCAN_N; i++) begin
      step((i == SCAN_N - 1) || (i == pauseAt), pattern[i]);
      outBits[i] = lastTdo;
      check(lastEn === 1'b1, "R10 tdoEn in Shift-DR", {63'd0, lastEn}, 64'd1);
      if (i == 0 && flipRing) ioRing = ~ioRing;
      if (i == pauseAt) begin
        step(0, 1); step(0, 1); step(1, 1); step(0, 1);
        check(lastEn === 1'b0, "R11 tdo off in Exit2", {63'd0, lastEn}, 64'd0);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [63:0] expScan(input int len, input logic [63:0] cap,
                                          input logic [63:0] pattern);
    logic [63:0] e = '0;
    for (int i = 0; i < SCAN_N; i++)
      e[i] = (i < len) ? cap[i] : pattern[i - len];
    return e;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] got, pat;
    #35 trstN = 1'b1;
    #2;
    check(tdoEn === 1'b0, "R2 reset tdoEn", {63'd0, tdoEn}, 64'd0);
    check(outDisable === 1'b0, "R2 reset outDisable", {63'd0, outDisable}, 64'd0);
    step(1, 0); step(1, 0);
    check(tdoEn === 1'b0, "R1 reset holds", {63'd0, tdoEn}, 64'd0);
    step(0, 0);

    // R7: identification after reset
    pat = 64'h0000_C3A5_96F0_1E2D;
    scanDr(pat, -1, 1'b0, got);
    check(got[SCAN_N-1:0] === expScan(32, {32'd0, ID_CODE}, pat)[SCAN_N-1:0],
          "R7 R1 id after reset", got, expScan(32, {32'd0, ID_CODE}, pat));

    // opcode sweep: R4 R5 R6 R7 R8 R9 R11 R12
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code = 3'(c);
      int len;
      logic [63:0] cap;
      bit expDis, bsrOp;
      ioRing = 12'hA5C ^ (12'h1B3 * 12'(c + 1));
      pat = {16'd0, 32'h5A3C_0F96 ^ (32'h0101_0101 * 32'(c)), 16'hC35A};
      loadIr(code);
      bsrOp  = (code == 3'b000) || (code == 3'b010) || (code == 3'b100);
      expDis = (code == 3'b000) || (code == 3'b010);
      if (bsrOp) begin len = BSR_LEN; cap = {52'd0, ioRing}; end
      else if (code == 3'b001) begin len = 32; cap = {32'd0, ID_CODE}; end
      else begin len = 1; cap = 64'd0; end
      check(outDisable === expDis, "R4 R5 R6 R8 R9 outDisable per opcode",
            {61'd0, code}, {63'd0, expDis});
      scanDr(pat, (c == 2 || c == 4) ? 5 : -1, 1'b1, got);
      check(got[SCAN_N-1:0] === expScan(len, cap, pat)[SCAN_N-1:0],
            "R4 R5 R6 R7 R8 R9 R11 R12 scan contents", got, expScan(len, cap, pat));
      check(outDisable === expDis, "R4 R5 R8 R9 outDisable held after scan",
            {63'd0, outDisable}, {63'd0, expDis});
    end

    // R2: five ones from Shift-DR
    loadIr(3'b000);
    check(outDisable === 1'b1, "R4 extest disables", {63'd0, outDisable}, 64'd1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    check(outDisable === 1'b0, "R2 five ones clears", {63'd0, outDisable}, 64'd0);
    step(0, 0);
    pat = 64'h0000_1234_5678_9ABC;
    scanDr(pat, -1, 1'b0, got);
    check(got[SCAN_N-1:0] === expScan(32, {32'd0, ID_CODE}, pat)[SCAN_N-1:0],
          "R2 id after five ones", got, expScan(32, {32'd0, ID_CODE}, pat));

    // R2: asynchronous reset mid-operation
    loadIr(3'b010);
    check(outDisable === 1'b1, "R5 samplez disables", {63'd0, outDisable}, 64'd1);
    @(negedge tck); #3 trstN = 1'b0; #2;
    check(outDisable === 1'b0, "R2 async reset clears", {63'd0, outDisable}, 64'd0);
    check(tdoEn === 1'b0, "R2 async reset tdoEn", {63'd0, tdoEn}, 64'd0);
    #2 trstN = 1'b1;
    step(0, 0);
    pat = 64'h0000_FEDC_BA98_7654;
    scanDr(pat, -1, 1'b0, got);
    check(got[SCAN_N-1:0] === expScan(32, {32'd0, ID_CODE}, pat)[SCAN_N-1:0],
          "R2 id after async reset", got, expScan(32, {32'd0, ID_CODE}, pat));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule